// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block walks a small file of 64-bit interrupt list entries, one entry per clock. It reports the single entry that is pending, enabled for its group and most urgent. A one-cycle start pulse samples the in-use count and begins the walk at index 0. When the walk ends, a one-cycle done pulse marks fresh results. The results are a found flag, the index of the winning entry and its full 64-bit value.

When no entry qualifies, found stays low and the value output carries the spurious identifier 1023. The results are registered. They keep their value until the next scan completes, so a consumer can read them at any later point.

Each entry has a 2-bit state field at bits 63:62, encoded 00 = inactive, 01 = pending, 10 = active and 11 = pending-and-active. A group bit sits at bit 60, where 0 = group 0 and 1 = group 1. An 8-bit priority sits at bits 55:48, and a lower number is more urgent. The remaining bits, including the identifier in bits 9:0, pass through untouched in the winning value.

Top module: `pend_prio_sel`

## Requirements
- R1: After reset, done_o and found_o are low, win_idx_o is 0 and win_val_o is 1023.
- R2: Only entries with an index below the in-use count sampled at start are examined; entries at or above it never win.
- R3: An entry is a candidate only when bits 63:62 equal 01 (pending); inactive (00), active (10) and pending-and-active (11) entries are skipped.
- R4: Bit 60 selects the enable that applies: a group-0 entry is skipped while grp0_en_i is low, and a group-1 entry is skipped while grp1_en_i is low.
- R5: Among candidates, the entry with the numerically lowest priority in bits 55:48 wins.
- R6: When candidates share the lowest priority, the one with the lowest index wins.
- R7: An entry with priority 0xFF is never selected.
- R8: When nothing qualifies, found_o is low, win_idx_o is 0 and win_val_o is 1023 zero-extended.
- R9: done_o rises at the clock edge that comes count edges after the edge that samples start, where count is the clamped in-use count (a count of 0 completes at the start edge). done_o is high for exactly one cycle.
- R10: found_o, win_idx_o and win_val_o hold their value between completions, even when the entries change.
- R11: An in-use count above NUM_ENTRIES is treated as NUM_ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a scan from index 0 |
| entries_i | input | NUM_ENTRIES*64 | Entry file; entry j occupies bits j*64 +: 64 |
| used_cnt_i | input | CNT_W | Number of entries in use, sampled at start |
| grp0_en_i | input | 1 | Enable for group-0 entries |
| grp1_en_i | input | 1 | Enable for group-1 entries |
| done_o | output | 1 | One-cycle pulse when results are updated |
| found_o | output | 1 | A qualifying entry was selected |
| win_idx_o | output | IDX_W | Index of the selected entry (0 when none) |
| win_val_o | output | 64 | Value of the selected entry, or 1023 when none |

## Verification
Some properties hold on every cycle, and the assertions check these: done is a single-cycle pulse, and the outputs hold between completions. A reported winner always has the pending encoding and a priority other than 0xFF. A miss always reports index 0 and identifier 1023, and the scan pointer never passes the sampled count. The bench scenarios cover what depends on the whole entry file: the ordering by priority, the tie break to the lowest index, the group enables, and the count limit with its clamp. The bench also measures the latency from start to done for each count.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int ENTRY_W   = 64;
  localparam int STATE_HI  = 63;
  localparam int STATE_LO  = 62;
  localparam int GRP_BIT   = 60;
  localparam int PRI_HI    = 55;
  localparam int PRI_LO    = 48;
  localparam int PRI_W     = PRI_HI - PRI_LO + 1;
  localparam int ID_W      = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_PACT = 2'b11
  } ent_state_e;

  localparam logic [PRI_W-1:0] PRI_IDLE = '1;
  localparam logic [ID_W-1:0]  SPUR_ID  = 10'd1023;
  localparam logic [ENTRY_W-1:0] SPUR_VAL = {{(ENTRY_W-ID_W){1'b0}}, SPUR_ID};
endpackage

// File: rtl/pps_qualify.sv
module pps_qualify
  import pps_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               grp0_en_i,
  input  logic               grp1_en_i,
  output logic               elig_o,
  output logic [PRI_W-1:0]   pri_o
);
  ent_state_e st;
  logic       grp_on;

  always_comb begin
    st     = ent_state_e'(entry_i[STATE_HI:STATE_LO]);
    grp_on = entry_i[GRP_BIT] ? grp1_en_i : grp0_en_i;
    elig_o = (st == ST_PEND) && grp_on;
    pri_o  = entry_i[PRI_HI:PRI_LO];
  end
endmodule

// File: rtl/pps_cmp.sv
module pps_cmp
  import pps_pkg::*;
(
  input  logic             elig_i,
  input  logic [PRI_W-1:0] cand_pri_i,
  input  logic [PRI_W-1:0] best_pri_i,
  output logic             take_o
);
  // Strict compare: equal priority keeps the earlier index, idle never wins
  assign take_o = elig_i && (cand_pri_i < best_pri_i);
endmodule

// File: rtl/pend_prio_sel.sv
module pend_prio_sel
  import pps_pkg::*;
#(
  parameter  int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [NUM_ENTRIES*ENTRY_W-1:0] entries_i,
  input  logic [CNT_W-1:0]               used_cnt_i,
  input  logic                           grp0_en_i,
  input  logic                           grp1_en_i,
  output logic                           done_o,
  output logic                           found_o,
  output logic [IDX_W-1:0]               win_idx_o,
  output logic [ENTRY_W-1:0]             win_val_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_ENTRIES);

  logic               busy_q;
  logic [IDX_W-1:0]   scan_idx_q;
  logic [CNT_W-1:0]   lim_q;
  logic [PRI_W-1:0]   best_pri_q;
  logic [IDX_W-1:0]   best_idx_q;
  logic [ENTRY_W-1:0] best_val_q;
  logic               best_hit_q;

  logic [CNT_W-1:0]   lim_in;
  logic [ENTRY_W-1:0] cur_entry;
  logic               cur_elig;
  logic [PRI_W-1:0]   cur_pri;
  logic               take;
  logic               last;

  logic [PRI_W-1:0]   nxt_pri;
  logic [IDX_W-1:0]   nxt_idx;
  logic [ENTRY_W-1:0] nxt_val;
  logic               nxt_hit;

  // Clamp the in-use count to the file depth
  assign lim_in    = (used_cnt_i > MAX_CNT) ? MAX_CNT : used_cnt_i;
  assign cur_entry = entries_i[int'(scan_idx_q)*ENTRY_W +: ENTRY_W];
  assign last      = (CNT_W'(scan_idx_q) + CNT_W'(1)) == lim_q;

  pps_qualify u_qual (
    .entry_i   (cur_entry),
    .grp0_en_i (grp0_en_i),
    .grp1_en_i (grp1_en_i),
    .elig_o    (cur_elig),
    .pri_o     (cur_pri)
  );

  pps_cmp u_cmp (
    .elig_i     (cur_elig),
    .cand_pri_i (cur_pri),
    .best_pri_i (best_pri_q),
    .take_o     (take)
  );

  always_comb begin
    nxt_pri = take ? cur_pri    : best_pri_q;
    nxt_idx = take ? scan_idx_q : best_idx_q;
    nxt_val = take ? cur_entry  : best_val_q;
    nxt_hit = take | best_hit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      scan_idx_q <= '0;
      lim_q      <= '0;
      best_pri_q <= PRI_IDLE;
      best_idx_q <= '0;
      best_val_q <= '0;
      best_hit_q <= 1'b0;
      done_o     <= 1'b0;
      found_o    <= 1'b0;
      win_idx_o  <= '0;
      win_val_o  <= SPUR_VAL;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        busy_q     <= (lim_in != '0);
        scan_idx_q <= '0;
        lim_q      <= lim_in;
        best_pri_q <= PRI_IDLE;
        best_idx_q <= '0;
        best_val_q <= '0;
        best_hit_q <= 1'b0;
        if (lim_in == '0) begin
          done_o    <= 1'b1;
          found_o   <= 1'b0;
          win_idx_o <= '0;
          win_val_o <= SPUR_VAL;
        end
      end else if (busy_q) begin
        best_pri_q <= nxt_pri;
        best_idx_q <= nxt_idx;
        best_val_q <= nxt_val;
        best_hit_q <= nxt_hit;
        scan_idx_q <= scan_idx_q + IDX_W'(1);
        if (last) begin
          busy_q    <= 1'b0;
          done_o    <= 1'b1;
          found_o   <= nxt_hit;
          win_idx_o <= nxt_hit ? nxt_idx : '0;
          win_val_o <= nxt_hit ? nxt_val : SPUR_VAL;
        end
      end
    end
  end

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !start |=> !done_o);

  // R8
  spurious_value_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !found_o |-> (win_val_o == SPUR_VAL) && (win_idx_o == '0));

  // R3
  won_pending_chk: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (win_val_o[STATE_HI:STATE_LO] == ST_PEND));

  // R7
  never_idle_pri_chk: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (win_val_o[PRI_HI:PRI_LO] != PRI_IDLE));

  // R10
  hold_between_done_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(win_val_o) && $stable(found_o) && $stable(win_idx_o));

  // R2
  scan_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (CNT_W'(scan_idx_q) < lim_q));
endmodule

// File: tb/pend_prio_sel_tb.sv
module pend_prio_sel_tb;
  localparam int N     = 8;
  localparam int CNT_W = $clog2(N + 1);
  localparam int IDX_W = $clog2(N);
  localparam int NV    = 12;

  // Entry descriptor: 3 hex digits {state[1:0], grp, 0, pri[7:0]}, entry 7 leftmost
  localparam logic [95:0] T_ENT [NV] = '{
    96'h65A65064663C61463261E628,   // R5 lowest priority wins
    96'h66466466466461E614614632,   // R6 tie -> lowest index
    96'h664664664664609207E06A05,   // R3 state filter
    96'h63263263263263263260A401,   // R4 group 0 disabled
    96'h60560560560560541E605601,   // R4 group 1 disabled
    96'h66466460166466463261E628,   // R2 count 3
    96'h6FF6FF6FF6FF6FF6FF6FF6FF,   // R7 idle priority only
    96'h210210210210210210210210,   // R8 nothing pending
    96'h65A65064663C61463261E628,   // R9 count 0
    96'h602664664664664664664664,   // R11 count above depth
    96'h6006FF6FF6FF6FF6FF6FF6FF,   // winner at last index
    96'h6006FF6FF6FF6FF6FF6FF6FF    // R2 winner just past count
  };
  localparam logic [CNT_W-1:0] T_CNT [NV] = '{8, 8, 8, 8, 8, 3, 8, 8, 0, 12, 8, 7};
  localparam logic [1:0]       T_EN  [NV] = '{3, 3, 3, 2, 1, 3, 3, 3, 3, 3, 3, 3};
  localparam logic             T_FND [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 0, 1, 1, 0};
  localparam int               T_IDX [NV] = '{3, 1, 3, 1, 2, 1, 0, 0, 0, 7, 7, 0};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [N*64-1:0]      entries = '0;
  logic [CNT_W-1:0]     used_cnt = '0;
  logic                 en0 = 1'b0, en1 = 1'b0;
  logic                 done, found;
  logic [IDX_W-1:0]     win_idx;
  logic [63:0]          win_val;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pend_prio_sel #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .start(start), .entries_i(entries),
    .used_cnt_i(used_cnt), .grp0_en_i(en0), .grp1_en_i(en1),
    .done_o(done), .found_o(found), .win_idx_o(win_idx), .win_val_o(win_val)
  );

  function automatic logic [63:0] mk(logic [11:0] d, int v, int j);
    logic [9:0] id;
    id = 10'(v * 16 + j + 16);
    return {d[11:10], 1'b0, d[9], 4'b0, d[7:0], 38'b0, id};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_scan(output int lat);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int lat;
    int exp_lat;
    logic [63:0] exp_val;
    logic [63:0] keep_val;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !found && win_idx == '0, "R1 flags", {62'b0, done, found}, 64'd0);
    chk(win_val == 64'd1023, "R1 value", win_val, 64'd1023);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      for (int j = 0; j < N; j++)
        entries[j*64 +: 64] = mk(T_ENT[v][j*12 +: 12], v, j);
      used_cnt = T_CNT[v];
      {en1, en0} = T_EN[v];
      exp_lat = (int'(T_CNT[v]) > N) ? N : int'(T_CNT[v]);
      exp_val = T_FND[v] ? mk(T_ENT[v][T_IDX[v]*12 +: 12], v, T_IDX[v]) : 64'd1023;
      run_scan(lat);
      // R9 latency
      chk(lat == exp_lat, $sformatf("R9 latency v%0d", v), 64'(lat), 64'(exp_lat));
      // R2 R3 R4 R5 R6 R7 R8 R11 result
      chk(found == T_FND[v], $sformatf("R5 found v%0d", v), {63'b0, found}, {63'b0, T_FND[v]});
      chk(int'(win_idx) == T_IDX[v], $sformatf("R6 index v%0d", v), 64'(win_idx), 64'(T_IDX[v]));
      chk(win_val == exp_val, $sformatf("R8 value v%0d", v), win_val, exp_val);
      @(negedge clk);
      chk(!done, $sformatf("R9 pulse v%0d", v), {63'b0, done}, 64'd0);
    end

    // R10 outputs hold while entries change and no scan runs
    keep_val = win_val;
    for (int j = 0; j < N; j++)
      entries[j*64 +: 64] = mk(12'h601, 99, j);
    repeat (6) @(negedge clk);
    chk(win_val == keep_val && !found, "R10 hold", win_val, keep_val);

    // R10 outputs hold during a scan until it completes
    used_cnt = CNT_W'(N);
    {en1, en0} = 2'b11;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chk(win_val == keep_val, "R10 mid-scan", win_val, keep_val);
    while (!done) @(negedge clk);
    exp_val = mk(12'h601, 99, 0);
    chk(found && win_idx == '0 && win_val == exp_val, "R6 all-equal", win_val, exp_val);

    // R1 reset after activity
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk(!found && win_val == 64'd1023, "R1 re-reset", win_val, 64'd1023);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule